// File: doc/BRIEF.md
# Ping-pong receive buffer for a USB OUT endpoint

This block is the receive storage behind one OUT endpoint of a full-speed USB device controller. It holds up to two whole packets in two equal halves of 128 bytes each, 256 bytes in all. A packet-receive engine reports each OUT token with a single strobe. The block answers with an accept or NAK decision, which depends on whether a whole half is free for the packet. After an accept, the engine streams bytes into the free half and closes the packet with an end-of-packet strobe. The closed half then becomes pending, and a sticky interrupt flag is raised.

On the other side, the processor drains the pending packets in the order they arrived. It reads one byte per read strobe from a 32-bit data word. The byte sits in bits 7:0 and the upper bits are always zero. A half is returned to the free pool on the same cycle its last byte is read, so that same cycle can already accept a new token. When both halves hold packets, every token is answered with NAK. Reading part of the oldest packet does not change this.

Top module: `usb_out_pingpong`

## Requirements
- R1: After a synchronous reset, `rd_data` is zero, `irq` is low, `resp_vld` is low and the buffer is empty, so the first token is accepted.
- R2: One cycle after `tok_start`, `resp_vld` is high for exactly one cycle, with `resp_ack`=1 (accept) when at least one half is free.
- R3: When both halves hold complete packets, a token is answered with `resp_ack`=0 (NAK). Partial draining of the oldest packet keeps the answer at NAK.
- R4: On the cycle the last byte of the oldest packet is read, its half counts as free: a token in that same cycle is accepted.
- R5: The cycle after an accepted `rd_stb`, `rd_data[7:0]` holds the next byte. Bytes come out in write order within a packet, and packets come out in arrival order. `rd_data[31:8]` is zero.
- R6: `rd_data` is zero in every cycle not preceded by a read strobe. A read strobe while nothing is pending returns zero and moves no pointer, so the next packet still starts at its first byte.
- R7: `irq` goes high the cycle after an `rx_eop` that closes an accepted packet. It stays high until `irq_clr`, and a new end of packet in the same cycle as `irq_clr` keeps it high.
- R8: After a NAK answer, bytes and the end-of-packet strobe of that packet are ignored: no data is stored and `irq` is not raised.
- R9: Bytes beyond 128 in one packet are dropped. The stored packet holds its first 128 bytes.
- R10: A packet closed with no bytes raises `irq` but occupies no half, and reading afterwards returns zero.
- R11: A `tok_start` while a packet is still open discards that partial packet and starts a new one.
- R12: A byte presented with `rx_valid` in the same cycle as `tok_start` or `rx_eop` is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_start | input | 1 | Strobe: an OUT token for this endpoint begins |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_eop | input | 1 | Strobe: end of the current received packet |
| resp_vld | output | 1 | Handshake decision valid (one cycle) |
| resp_ack | output | 1 | 1 = accept data, 0 = answer NAK |
| rd_stb | input | 1 | Processor read strobe for the data word |
| rd_data | output | 32 | Data word; byte in bits 7:0, upper bits zero |
| irq_clr | input | 1 | Write-one-to-clear strobe for the interrupt |
| irq | output | 1 | Sticky packet-complete interrupt |

## Verification
A wrong fill flag or a stale half selector shows up in two ways. It can appear as a wrong accept/NAK bit one cycle after the next token. Or the next read strobe returns a byte from the wrong packet one cycle later. A wrong count shows up at the packet boundary: a short count returns a byte of the following packet too early, and a long count returns a stale byte or zero where a real byte was due. The bench drives overlapping fill and drain, a token on the exact draining cycle, aborts, oversize and empty packets. It compares all four outputs against a queue model on every cycle, so a divergence is caught within one clock of the first visible effect.

// File: rtl/oep_pkg.sv
package oep_pkg;
  typedef logic [7:0] oep_byte_t;
  localparam int OEP_HALVES = 2;
endpackage

// File: rtl/oep_store.sv
module oep_store #(
  parameter int HALF_BYTES = 128,
  localparam int AW = $clog2(2 * HALF_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  oep_pkg::oep_byte_t wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output oep_pkg::oep_byte_t q
);
  oep_pkg::oep_byte_t mem [2*HALF_BYTES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (re) q <= mem[raddr];
    else         q <= '0;
  end
endmodule

// File: rtl/oep_fill.sv
module oep_fill #(
  parameter int HALF_BYTES = 128,
  localparam int IDXW = $clog2(HALF_BYTES),
  localparam int LENW = $clog2(HALF_BYTES + 1),
  localparam int AW = IDXW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tok_start,
  input  logic              rx_valid,
  input  oep_pkg::oep_byte_t rx_data,
  input  logic              rx_eop,
  input  logic              space,
  output logic              resp_vld,
  output logic              resp_ack,
  output logic              wr_sel,
  output logic              we,
  output logic [AW-1:0]     waddr,
  output oep_pkg::oep_byte_t wdata,
  output logic              commit,
  output logic [LENW-1:0]   commit_len
);
  localparam logic [LENW-1:0] CAP = LENW'(HALF_BYTES);

  logic            open_q;
  logic [LENW-1:0] cnt_q;

  always_comb begin
    we         = open_q && !tok_start && !rx_eop && rx_valid && (cnt_q != CAP);
    waddr      = {wr_sel, cnt_q[IDXW-1:0]};
    wdata      = rx_data;
    commit     = open_q && !tok_start && rx_eop;
    commit_len = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q   <= 1'b0;
      cnt_q    <= '0;
      wr_sel   <= 1'b0;
      resp_vld <= 1'b0;
      resp_ack <= 1'b0;
    end else begin
      resp_vld <= tok_start;
      if (tok_start) begin
        resp_ack <= space;
        open_q   <= space;
        cnt_q    <= '0;
      end else if (open_q) begin
        if (rx_eop) begin
          open_q <= 1'b0;
          if (cnt_q != '0) wr_sel <= ~wr_sel;
        end else if (we) begin
          cnt_q <= cnt_q + LENW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/oep_drain.sv
module oep_drain #(
  parameter int HALF_BYTES = 128,
  localparam int IDXW = $clog2(HALF_BYTES),
  localparam int LENW = $clog2(HALF_BYTES + 1),
  localparam int AW = IDXW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_stb,
  input  logic [1:0]           full,
  input  logic [1:0][LENW-1:0] len,
  output logic                 re,
  output logic [AW-1:0]        raddr,
  output logic                 done,
  output logic                 done_half
);
  logic            sel_q;
  logic [LENW-1:0] cnt_q;
  logic [LENW-1:0] cnt_nx;

  always_comb begin
    cnt_nx    = cnt_q + LENW'(1);
    re        = rd_stb && full[sel_q];
    raddr     = {sel_q, cnt_q[IDXW-1:0]};
    done      = re && (cnt_nx == len[sel_q]);
    done_half = sel_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 1'b0;
      cnt_q <= '0;
    end else if (done) begin
      sel_q <= ~sel_q;
      cnt_q <= '0;
    end else if (re) begin
      cnt_q <= cnt_nx;
    end
  end
endmodule

// File: rtl/usb_out_pingpong.sv
module usb_out_pingpong #(
  parameter int HALF_BYTES = 128,
  parameter int DATA_W = 32,
  localparam int IDXW = $clog2(HALF_BYTES),
  localparam int LENW = $clog2(HALF_BYTES + 1),
  localparam int AW = IDXW + 1,
  localparam int PAD = DATA_W - 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tok_start,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_eop,
  output logic              resp_vld,
  output logic              resp_ack,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rd_data,
  input  logic              irq_clr,
  output logic              irq
);
  logic [1:0]           full_q;
  logic [1:0][LENW-1:0] len_q;
  logic                 wr_sel, wr_en, commit, done, done_half, rd_en, space;
  logic [AW-1:0]        wr_addr, rd_addr;
  logic [LENW-1:0]      commit_len;
  oep_pkg::oep_byte_t   wr_byte, rd_byte;

  assign space = !full_q[wr_sel] || (done && (done_half == wr_sel));

  oep_fill #(.HALF_BYTES(HALF_BYTES)) fill_i (
    .clk(clk), .rst(rst), .tok_start(tok_start), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_eop(rx_eop), .space(space),
    .resp_vld(resp_vld), .resp_ack(resp_ack), .wr_sel(wr_sel),
    .we(wr_en), .waddr(wr_addr), .wdata(wr_byte),
    .commit(commit), .commit_len(commit_len)
  );

  oep_drain #(.HALF_BYTES(HALF_BYTES)) drain_i (
    .clk(clk), .rst(rst), .rd_stb(rd_stb), .full(full_q), .len(len_q),
    .re(rd_en), .raddr(rd_addr), .done(done), .done_half(done_half)
  );

  oep_store #(.HALF_BYTES(HALF_BYTES)) store_i (
    .clk(clk), .rst(rst), .we(wr_en), .waddr(wr_addr), .wdata(wr_byte),
    .re(rd_en), .raddr(rd_addr), .q(rd_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= '0;
      len_q  <= '0;
    end else begin
      for (int h = 0; h < oep_pkg::OEP_HALVES; h++) begin
        if (commit && (wr_sel == 1'(h)) && (commit_len != '0)) begin
          full_q[h] <= 1'b1;
          len_q[h]  <= commit_len;
        end else if (done && (done_half == 1'(h))) begin
          full_q[h] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= commit || (irq && !irq_clr);
  end

  assign rd_data = {{PAD{1'b0}}, rd_byte};
endmodule

// File: rtl/usb_out_pingpong_chk.sv
module usb_out_pingpong_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              tok_start,
  input logic              rx_eop,
  input logic              rd_stb,
  input logic              irq_clr,
  input logic              resp_vld,
  input logic              resp_ack,
  input logic              irq,
  input logic [DATA_W-1:0] rd_data,
  input logic [1:0]        full_q,
  input logic              we,
  input logic              wr_sel
);
  AST_TOKEN_ANSWERED: assert property (@(posedge clk) disable iff (rst) tok_start |=> resp_vld); // R2
  AST_BOTH_FULL_NAK: assert property (@(posedge clk) disable iff (rst) (tok_start && full_q == 2'b11 && !rd_stb) |=> !resp_ack); // R3
  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (rst) we |-> !full_q[wr_sel]); // R3
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst) !rd_stb |=> (rd_data == '0)); // R6
  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (rst) (irq && !irq_clr) |=> irq); // R7
  AST_IRQ_NEEDS_EOP: assert property (@(posedge clk) disable iff (rst) (!irq && !rx_eop) |=> !irq); // R7
endmodule

bind usb_out_pingpong usb_out_pingpong_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .tok_start(tok_start), .rx_eop(rx_eop), .rd_stb(rd_stb),
  .irq_clr(irq_clr), .resp_vld(resp_vld), .resp_ack(resp_ack), .irq(irq),
  .rd_data(rd_data), .full_q(full_q), .we(wr_en), .wr_sel(wr_sel)
);

// File: tb/usb_out_pingpong_tb_top.sv
module usb_out_pingpong_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tok_start = 0, rx_valid = 0, rx_eop = 0, rd_stb = 0, irq_clr = 0;
  logic [7:0] rx_data = 8'h00;
  logic resp_vld, resp_ack, irq;
  logic [31:0] rd_data;

  always #4 clk = ~clk;

  usb_out_pingpong dut_i (
    .clk(clk), .rst(rst), .tok_start(tok_start), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_eop(rx_eop), .resp_vld(resp_vld), .resp_ack(resp_ack),
    .rd_stb(rd_stb), .rd_data(rd_data), .irq_clr(irq_clr), .irq(irq)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  string tag = "R1";

  // behavioural reference
  logic [7:0] stored[$];
  int plen[$];
  logic [7:0] cur[$];
  int rdpos;
  bit m_open, sp, eset;
  logic [31:0] exp_rd;
  bit exp_vld, exp_ack, exp_irq;

  always @(posedge clk) begin
    if (rst) begin
      stored.delete(); plen.delete(); cur.delete();
      rdpos = 0; m_open = 0; exp_rd = 0; exp_vld = 0; exp_ack = 0; exp_irq = 0;
    end else begin
      eset = 0;
      sp = (plen.size() < 2) || (rd_stb && plen.size() > 0 && rdpos + 1 == plen[0]);
      if (rd_stb && plen.size() > 0) begin
        exp_rd = {24'h0, stored.pop_front()};
        rdpos++;
        if (rdpos == plen[0]) begin void'(plen.pop_front()); rdpos = 0; end
      end else exp_rd = 0;
      exp_vld = tok_start;
      if (tok_start) begin
        exp_ack = sp; m_open = sp; cur.delete();
      end else if (m_open) begin
        if (rx_eop) begin
          m_open = 0; eset = 1;
          if (cur.size() > 0) begin
            foreach (cur[i]) stored.push_back(cur[i]);
            plen.push_back(cur.size());
          end
        end else if (rx_valid && cur.size() < 128) cur.push_back(rx_data);
      end
      exp_irq = eset || (exp_irq && !irq_clr);
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s [%s] act=%h exp=%h t=%0t", req, tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    chk("R5 rd_data", rd_data, exp_rd);
    chk("R7 irq", {31'h0, irq}, {31'h0, exp_irq});
    chk("R2 resp_vld", {31'h0, resp_vld}, {31'h0, exp_vld});
    if (exp_vld) chk("R3 resp_ack", {31'h0, resp_ack}, {31'h0, exp_ack});
    tok_start = 0; rx_valid = 0; rx_eop = 0; rd_stb = 0; irq_clr = 0;
  endtask

  task automatic tok(); tok_start = 1; tick(); endtask
  task automatic put(input logic [7:0] b); rx_valid = 1; rx_data = b; tick(); endtask
  task automatic eop(); rx_eop = 1; tick(); endtask
  task automatic rd(); rd_stb = 1; tick(); endtask
  task automatic clr(); irq_clr = 1; tick(); endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    tag = "R1";
    tick();
    chk("R1 rd_data", rd_data, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    tok(); chk("R1 first ack", {31'h0, resp_ack}, 32'h1);
    tag = "R2";
    for (int i = 0; i < 4; i++) put(8'h10 + 8'(i));
    eop(); chk("R7 irq set", {31'h0, irq}, 32'h1);
    tick(); chk("R7 irq sticky", {31'h0, irq}, 32'h1);
    clr(); chk("R7 irq cleared", {31'h0, irq}, 32'h0);
    tok(); chk("R2 second ack", {31'h0, resp_ack}, 32'h1);
    for (int i = 0; i < 3; i++) put(8'h20 + 8'(i));
    eop(); clr();
    tag = "R3";
    tok(); chk("R3 nak", {31'h0, resp_ack}, 32'h0);
    tag = "R8";
    put(8'hEE); put(8'hEF); eop();
    chk("R8 no irq", {31'h0, irq}, 32'h0);
    tag = "R5";
    rd(); chk("R5 byte0", rd_data, 32'h10);
    rd(); chk("R5 byte1", rd_data, 32'h11);
    tag = "R3";
    tok(); chk("R3 nak after partial", {31'h0, resp_ack}, 32'h0);
    rd();
    tag = "R4";
    rd_stb = 1; tok_start = 1; tick();
    chk("R4 last byte", rd_data, 32'h13);
    chk("R4 ack same cycle", {31'h0, resp_ack}, 32'h1);
    tag = "R12";
    put(8'h30); put(8'h31);
    rx_valid = 1; rx_data = 8'h98; rx_eop = 1; tick();
    tag = "R5";
    for (int i = 0; i < 5; i++) rd();
    tag = "R6";
    rd(); chk("R6 empty read", rd_data, 32'h0);
    tick(); tok(); put(8'h41); put(8'h42); eop();
    rd(); chk("R6 no pointer move", rd_data, 32'h41);
    rd();
    tag = "R9";
    tok();
    for (int i = 0; i < 130; i++) put(8'(i + 1));
    eop();
    for (int i = 0; i < 129; i++) rd();
    chk("R9 dropped tail", rd_data, 32'h0);
    tag = "R10";
    clr(); tok(); eop(); chk("R10 irq", {31'h0, irq}, 32'h1);
    rd(); chk("R10 nothing stored", rd_data, 32'h0);
    tag = "R11";
    tok(); put(8'h50); put(8'h51); tok(); put(8'h60);
    tag = "R7";
    rx_eop = 1; irq_clr = 1; tick();
    chk("R7 set wins", {31'h0, irq}, 32'h1);
    tag = "R11";
    rd(); chk("R11 new packet only", rd_data, 32'h60);
    rd(); chk("R11 partial discarded", rd_data, 32'h0);
    tick(); tick();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog [%s] act=timeout exp=done", tag);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule